// File: doc/BRIEF.md
# Sticky-Preserving Significand Multiplier

This block forms the product of two normalised binary significands, each carrying its hidden leading one, as the multiply half of a fused multiply-add datapath. Each significand is placed at the top of a machine word. The two words are multiplied from half-word partial products into a double-word result. Only the upper word is kept, and every discarded lower bit is folded into a sticky flag. A one-place normalisation, chosen by the upper bit of the product, then brings the result to a fixed width. That width is the significand plus three extra bits for guard, round and sticky. The block also adds the two unbiased exponents, adds one when the product needed the wider shift, and forms the sign of the product.

The block is a library primitive. Every width is a parameter, and the defaults fit single precision: a 24-bit significand, a 32-bit word, 16-bit halves, 3 extra bits and a 10-bit signed exponent. A parameter selects a purely combinational form or a form with one register stage, in which the valid flag travels with the data. Operands that are zero, infinite, not-a-number or denormal are resolved outside this block. Only normalised significands are presented here.

Top module: `sigmul_core`

## Requirements
- R1: With inputs a and b, both having bit MANT_W-1 set, let P = a*b be the exact integer product. `out_sig` is P shifted right by k with a sticky fold. The value of k is 2*MANT_W-OUT_W when bit 2*MANT_W-1 of P is set, and 2*MANT_W-1-OUT_W otherwise. OUT_W is MANT_W+GRS_W, which is 27 by default.
- R2: When the product's upper bit (bit 2*MANT_W-1 of P) is set, the wider shift is used and `out_exp` equals in_exp_a + in_exp_b + 1.
- R3: When that upper bit is clear, the narrower shift is used and `out_exp` equals in_exp_a + in_exp_b.
- R4: Bit 0 of `out_sig` is the OR of the bit that lands there and every bit of P below it. This includes bits that fall only in the discarded lower product word.
- R5: For normalised inputs, bit OUT_W-1 of `out_sig` is always set.
- R6: `out_sign` is in_sign_a XOR in_sign_b.
- R7: Exponents are two's complement EXP_W-bit values. For inputs in -126..127 the result, including the +1, is exact with no wrap.
- R8: With PIPE_STAGES=0, outputs follow inputs in the same cycle and `out_vld` equals `in_vld`. With PIPE_STAGES=1, each output appears one rising edge after its input, `out_vld` is in_vld delayed by one edge, and `out_vld` is 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operands valid |
| in_sig_a | input | MANT_W | First significand, hidden bit at MSB |
| in_sig_b | input | MANT_W | Second significand, hidden bit at MSB |
| in_exp_a | input | EXP_W | First unbiased exponent, signed |
| in_exp_b | input | EXP_W | Second unbiased exponent, signed |
| in_sign_a | input | 1 | First sign |
| in_sign_b | input | 1 | Second sign |
| out_vld | output | 1 | Result valid |
| out_sig | output | OUT_W | Normalised product significand with guard, round, sticky |
| out_exp | output | EXP_W | Product exponent, signed |
| out_sign | output | 1 | Product sign |

## Verification
A reduced configuration with an 8-bit significand, 16-bit word and 8-bit halves is driven through the registered form. It is swept over every pair of normalised significands. That covers every carry pattern between partial products and both normalisation branches, and it separates the two shift amounts from each other. The default single-precision configuration runs in combinational form. It is given corner operands: the smallest and largest significands, and a pair whose only nonzero low product bits sit in the dropped lower word, which exposes a lost sticky fold. It is also given pseudo-random operands. Exponents at the ends of the single-precision range show whether the adjust and the sum wrap.

// File: rtl/sigmul_pkg.sv
package sigmul_pkg;
   localparam int SIGMUL_MANT_W = 24;
   localparam int SIGMUL_WORD_W = 32;
   localparam int SIGMUL_HALF_W = 16;
   localparam int SIGMUL_GRS_W  = 3;
   localparam int SIGMUL_EXP_W  = 10;
   localparam int SIGMUL_NPART  = 4;
endpackage

// File: rtl/sigmul_pp.sv
module sigmul_pp #(
   parameter int WORD_W = sigmul_pkg::SIGMUL_WORD_W,
   parameter int HALF_W = sigmul_pkg::SIGMUL_HALF_W
) (
   input  logic [WORD_W-1:0] opa,
   input  logic [WORD_W-1:0] opb,
   output logic [WORD_W-1:0] prod_hi,
   output logic              lo_nz
);
   localparam int DW = 2 * WORD_W;

   logic [HALF_W-1:0] a_half [2];
   logic [HALF_W-1:0] b_half [2];
   logic [DW-1:0]     term   [sigmul_pkg::SIGMUL_NPART];
   logic [DW-1:0]     acc;

   assign a_half[0] = opa[HALF_W-1:0];
   assign a_half[1] = opa[WORD_W-1:HALF_W];
   assign b_half[0] = opb[HALF_W-1:0];
   assign b_half[1] = opb[WORD_W-1:HALF_W];

   for (genvar i = 0; i < 2; i++) begin : g_row
      for (genvar j = 0; j < 2; j++) begin : g_col
         logic [2*HALF_W-1:0] part;
         assign part = {{HALF_W{1'b0}}, a_half[i]} * {{HALF_W{1'b0}}, b_half[j]};
         assign term[2*i+j] = {{(DW-2*HALF_W){1'b0}}, part} << (HALF_W * (i + j));
      end
   end

   assign acc     = term[0] + term[1] + term[2] + term[3];
   assign prod_hi = acc[DW-1:WORD_W];
   assign lo_nz   = |acc[WORD_W-1:0];

   // two left-justified normalised operands put a one in one of the top two bits
   always_comb begin
      if (opa[WORD_W-1] && opb[WORD_W-1]) begin
         p_pp_top_r1: assert (prod_hi[WORD_W-1] || prod_hi[WORD_W-2]);
      end
   end
endmodule

// File: rtl/sigmul_norm.sv
module sigmul_norm #(
   parameter int WORD_W = sigmul_pkg::SIGMUL_WORD_W,
   parameter int OUT_W  = sigmul_pkg::SIGMUL_MANT_W + sigmul_pkg::SIGMUL_GRS_W
) (
   input  logic [WORD_W-1:0] prod_hi,
   input  logic              lo_nz,
   output logic [OUT_W-1:0]  sig,
   output logic              exp_inc
);
   localparam int SH = WORD_W - OUT_W;

   logic [WORD_W-1:0] folded;
   logic [OUT_W-1:0]  wide_sh;
   logic [OUT_W-1:0]  narrow_sh;
   logic              wide_st;
   logic              narrow_st;

   assign folded    = {prod_hi[WORD_W-1:1], prod_hi[0] | lo_nz};
   assign wide_sh   = folded[WORD_W-1:SH];
   assign wide_st   = |folded[SH-1:0];
   assign narrow_sh = folded[WORD_W-2:SH-1];
   assign narrow_st = |folded[SH-2:0];
   assign exp_inc   = folded[WORD_W-1];

   always_comb begin
      if (exp_inc) sig = {wide_sh[OUT_W-1:1], wide_sh[0] | wide_st};
      else         sig = {narrow_sh[OUT_W-1:1], narrow_sh[0] | narrow_st};
   end

   always_comb begin
      if (lo_nz) begin
         p_sticky_keep_r4: assert (sig[0]);
      end
      if (prod_hi[WORD_W-1] || prod_hi[WORD_W-2]) begin
         p_norm_top_r5: assert (sig[OUT_W-1]);
      end
   end
endmodule

// File: rtl/sigmul_core.sv
module sigmul_core #(
   parameter int MANT_W      = sigmul_pkg::SIGMUL_MANT_W,
   parameter int WORD_W      = sigmul_pkg::SIGMUL_WORD_W,
   parameter int HALF_W      = sigmul_pkg::SIGMUL_HALF_W,
   parameter int GRS_W       = sigmul_pkg::SIGMUL_GRS_W,
   parameter int EXP_W       = sigmul_pkg::SIGMUL_EXP_W,
   parameter int PIPE_STAGES = 1,
   localparam int OUT_W      = MANT_W + GRS_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic [MANT_W-1:0]       in_sig_a,
   input  logic [MANT_W-1:0]       in_sig_b,
   input  logic signed [EXP_W-1:0] in_exp_a,
   input  logic signed [EXP_W-1:0] in_exp_b,
   input  logic                    in_sign_a,
   input  logic                    in_sign_b,
   output logic                    out_vld,
   output logic [OUT_W-1:0]        out_sig,
   output logic signed [EXP_W-1:0] out_exp,
   output logic                    out_sign
);
   localparam int JUST = WORD_W - MANT_W;

   if (WORD_W != 2 * HALF_W) begin : g_bad_half
      $error("sigmul_core: WORD_W must be twice HALF_W");
   end
   if (JUST < 1) begin : g_bad_word
      $error("sigmul_core: WORD_W must exceed MANT_W");
   end
   if (WORD_W - OUT_W < 2) begin : g_bad_out
      $error("sigmul_core: WORD_W must exceed OUT_W by at least 2");
   end
   if (PIPE_STAGES != 0 && PIPE_STAGES != 1) begin : g_bad_pipe
      $error("sigmul_core: PIPE_STAGES must be 0 or 1");
   end

   logic [WORD_W-1:0]       opa_j, opb_j, prod_hi;
   logic                    lo_nz, exp_inc;
   logic [OUT_W-1:0]        c_sig;
   logic signed [EXP_W-1:0] c_exp;
   logic                    c_sign;

   assign opa_j = {in_sig_a, {JUST{1'b0}}};
   assign opb_j = {in_sig_b, {JUST{1'b0}}};

   sigmul_pp #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_pp (
      .opa(opa_j), .opb(opb_j), .prod_hi(prod_hi), .lo_nz(lo_nz)
   );

   sigmul_norm #(.WORD_W(WORD_W), .OUT_W(OUT_W)) u_norm (
      .prod_hi(prod_hi), .lo_nz(lo_nz), .sig(c_sig), .exp_inc(exp_inc)
   );

   assign c_exp  = in_exp_a + in_exp_b + {{(EXP_W-1){1'b0}}, exp_inc};
   assign c_sign = in_sign_a ^ in_sign_b;

   if (PIPE_STAGES == 0) begin : g_comb
      assign out_vld  = in_vld;
      assign out_sig  = c_sig;
      assign out_exp  = c_exp;
      assign out_sign = c_sign;
   end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_vld  <= 1'b0;
            out_sig  <= '0;
            out_exp  <= '0;
            out_sign <= 1'b0;
         end else begin
            out_vld  <= in_vld;
            out_sig  <= c_sig;
            out_exp  <= c_exp;
            out_sign <= c_sign;
         end
      end

      p_vld_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> out_vld);
      p_sign_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> (out_sign == $past(in_sign_a ^ in_sign_b)));
      p_exp_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> ((out_exp == $past(in_exp_a + in_exp_b)) ||
                     (out_exp == $past(in_exp_a + in_exp_b) + 1'b1)));
   end

   p_hidden_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> (in_sig_a[MANT_W-1] && in_sig_b[MANT_W-1]));
   p_out_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> out_sig[OUT_W-1]);
endmodule

// File: tb/sigmul_core_bench.sv
`timescale 1ns/1ps
module sigmul_core_bench;
   localparam int SM = 8,  SW = 16, SH = 8;
   localparam int WM = 24, WW = 32, WH = 16;
   localparam int GRS = 3, EW = 10;
   localparam int SO = SM + GRS;
   localparam int WO = WM + GRS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   // reduced configuration, registered
   logic s_vld, s_sa, s_sb, s_ovld, s_osign;
   logic [SM-1:0] s_a, s_b;
   logic signed [EW-1:0] s_ea, s_eb, s_oexp;
   logic [SO-1:0] s_osig;

   sigmul_core #(.MANT_W(SM), .WORD_W(SW), .HALF_W(SH), .GRS_W(GRS),
                 .EXP_W(EW), .PIPE_STAGES(1)) u_sigmul_core (
      .clk(clk), .rst_n(rst_n), .in_vld(s_vld), .in_sig_a(s_a), .in_sig_b(s_b),
      .in_exp_a(s_ea), .in_exp_b(s_eb), .in_sign_a(s_sa), .in_sign_b(s_sb),
      .out_vld(s_ovld), .out_sig(s_osig), .out_exp(s_oexp), .out_sign(s_osign));

   // default configuration, combinational
   logic w_vld, w_sa, w_sb, w_ovld, w_osign;
   logic [WM-1:0] w_a, w_b;
   logic signed [EW-1:0] w_ea, w_eb, w_oexp;
   logic [WO-1:0] w_osig;

   sigmul_core #(.MANT_W(WM), .WORD_W(WW), .HALF_W(WH), .GRS_W(GRS),
                 .EXP_W(EW), .PIPE_STAGES(0)) u_sigmul_core_wide (
      .clk(clk), .rst_n(rst_n), .in_vld(w_vld), .in_sig_a(w_a), .in_sig_b(w_b),
      .in_exp_a(w_ea), .in_exp_b(w_eb), .in_sign_a(w_sa), .in_sign_b(w_sb),
      .out_vld(w_ovld), .out_sig(w_osig), .out_exp(w_oexp), .out_sign(w_osign));

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // expected significand, upper-bit flag, from the exact product
   task automatic model(input int m, input int ow, input longint a, input longint b,
                        output longint sig, output bit top);
      longint p, k;
      p   = a * b;
      top = p[2*m-1];
      k   = top ? (2*m - ow) : (2*m - 1 - ow);
      sig = p >> k;
      if ((p & ((64'sd1 <<< k) - 1)) != 0) sig = sig | 1;
   endtask

   task automatic judge(input int ow, input longint act_sig, input int act_exp,
                        input bit act_sign, input longint a, input longint b,
                        input int m, input int ea, input int eb, input bit sa, input bit sb);
      longint es; bit top; int ee;
      model(m, ow, a, b, es, top);
      ee = ea + eb + (top ? 1 : 0);
      check(act_sig == es, "R1 significand", act_sig, es);
      check(act_sig[ow-1], "R5 top bit", act_sig, es);
      if (top) check(act_exp == ee, "R2 exponent+1", act_exp, ee);
      else     check(act_exp == ee, "R3 exponent", act_exp, ee);
      check(act_sign == (sa ^ sb), "R6 sign", act_sign, sa ^ sb);
   endtask

   task automatic run_wide(input longint a, input longint b, input int ea, input int eb,
                           input bit sa, input bit sb);
      @(negedge clk);
      w_vld = 1'b1; w_a = WM'(a); w_b = WM'(b);
      w_ea = EW'(ea); w_eb = EW'(eb); w_sa = sa; w_sb = sb;
      #1;
      check(w_ovld == 1'b1, "R8 comb valid", w_ovld, 1);
      judge(WO, longint'(w_osig), int'(w_oexp), w_osign, a, b, WM, ea, eb, sa, sb);
   endtask

   initial begin
      longint es; bit top;
      s_vld = 0; s_a = '0; s_b = '0; s_ea = '0; s_eb = '0; s_sa = 0; s_sb = 0;
      w_vld = 0; w_a = '0; w_b = '0; w_ea = '0; w_eb = '0; w_sa = 0; w_sb = 0;
      repeat (3) @(negedge clk);
      check(s_ovld == 1'b0, "R8 reset valid", s_ovld, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(s_ovld == 1'b0, "R8 idle valid", s_ovld, 0);

      // exhaustive sweep of the reduced configuration
      for (int a = 128; a < 256; a++) begin
         for (int b = 128; b < 256; b++) begin
            int ea, eb; bit sa, sb;
            ea = ((a * 7 + b) % 254) - 126;
            eb = ((b * 5 + a * 3) % 254) - 126;
            sa = a[0]; sb = b[1];
            s_vld = 1'b1; s_a = SM'(a); s_b = SM'(b);
            s_ea = EW'(ea); s_eb = EW'(eb); s_sa = sa; s_sb = sb;
            @(negedge clk);
            check(s_ovld == 1'b1, "R8 one-edge valid", s_ovld, 1);
            judge(SO, longint'(s_osig), int'(s_oexp), s_osign, a, b, SM, ea, eb, sa, sb);
         end
      end
      s_vld = 1'b0;
      @(negedge clk);
      check(s_ovld == 1'b0, "R8 valid drops", s_ovld, 0);

      // default configuration corners
      run_wide(64'h800000, 64'h800000, 0, 0, 0, 0);          // exact, narrow shift (R3)
      check(w_osig == WO'(64'h4000000), "R3 min*min", w_osig, 64'h4000000);
      run_wide(64'hFFFFFF, 64'hFFFFFF, 127, 127, 1, 0);      // wide shift, max exp (R2, R7)
      check(w_oexp == 10'sd255, "R7 no wrap high", w_oexp, 255);
      run_wide(64'h800001, 64'h800001, -126, -126, 1, 1);    // sticky from low word only (R4)
      model(WM, WO, 64'h800001, 64'h800001, es, top);
      check(w_osig[0] == 1'b1, "R4 low word sticky", w_osig, es);
      check(w_oexp == -10'sd252, "R7 no wrap low", w_oexp, -252);
      run_wide(64'hC00000, 64'hAAAAAB, 5, -3, 0, 1);
      run_wide(64'hB504F3, 64'hB504F3, 1, 1, 1, 1);          // near the branch boundary
      for (int i = 0; i < 4000; i++) begin
         longint a, b; int ea, eb;
         a  = 64'h800000 | longint'($urandom & 32'h7FFFFF);
         b  = 64'h800000 | longint'($urandom & 32'h7FFFFF);
         ea = int'($urandom % 254) - 126;
         eb = int'($urandom % 254) - 126;
         run_wide(a, b, ea, eb, i[0], i[2]);
      end
      w_vld = 1'b0;
      #1;
      check(w_ovld == 1'b0, "R8 comb valid drops", w_ovld, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule